// File: doc/BRIEF.md
# Region-Aware Flash Block Eraser

This block carries out the erase step of a NOR-style flash array model. A controller hands it a byte offset together with a one-cycle start pulse. The block works out which erase region holds that offset and clears the low address bits to reach the start of the enclosing erase block. It then writes the erased value (all ones) into that block, one array word per clock cycle, and ends with a one-cycle done pulse.

The erase regions are set at elaboration time as two parameter lists: a block count and a log2 block size for each region. The regions sit back to back from byte zero. Block sizes may differ from one region to the next, so the block chosen depends on the region that the offset falls in. If zero regions are configured, the request erases the whole array. An offset at or past the end of the last region writes nothing but still completes. The array write port is a plain strobe with address and data. It has no back-pressure, because the array takes one word in every cycle.

Top module: `erase_block_engine`

## Requirements
- R1: Region 0 begins at byte 0, and each later region begins at the byte where the previous one ends. A region spans block count times 2^log2size bytes.
- R2: The region used is the lowest-numbered region whose end byte is strictly greater than the offset.
- R3: A hit writes exactly 2^log2size / WORD_BYTES words. The first word address is (offset with its low log2size bits cleared) divided by WORD_BYTES. Each following write goes to the next word address, one write per cycle, with no gaps.
- R4: Every array write carries all data bits set to 1.
- R5: With NUM_RGN = 0, every request writes the whole array, from word 0 up to the last word, whatever the offset.
- R6: An offset at or past the end of the last region produces no array write. Done is then raised in the first cycle after the start is sampled.
- R7: Busy is high from the cycle after an accepted start through the done cycle, and low in the cycle after done.
- R8: A start pulse that arrives while busy is high, including in the done cycle, is ignored. It changes neither the running write sequence nor the idle state that follows.
- R9: Done is high for exactly one cycle, in the cycle right after the last array write. Write enable is low in that cycle.
- R10: Out of reset, busy, done and write enable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Erase request pulse, accepted only when idle |
| offset_i | input | ADDR_W | Byte offset inside the array |
| busy_o | output | 1 | Erase in progress, done cycle included |
| done_o | output | 1 | One-cycle completion pulse |
| arr_we_o | output | 1 | Array word write strobe |
| arr_addr_o | output | ADDR_W-WB_LOG2 | Array word address |
| arr_wdata_o | output | 8<<WB_LOG2 | Array write data (all ones) |

## Verification
The properties assume a legal configuration. Every block size is at least one array word, and the regions fit inside the array, so a fill never crosses the top word address while incrementing. The bench keeps to this by using only small configurations that fit. It sweeps every byte offset of the array one at a time, waiting for idle between requests. Extra start pulses are sent only at chosen points inside a running erase, so that the ignore rule is exercised.

// File: rtl/erase_pkg.sv
package erase_pkg;
  localparam int unsigned MAX_RGN = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DONE = 2'd2
  } erase_state_t;
endpackage

// File: rtl/erase_region_lookup.sv
module erase_region_lookup
  import erase_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned WB_LOG2 = 1,
  parameter int unsigned NUM_RGN = 3,
  parameter int unsigned RGN_BLOCKS [MAX_RGN] = '{4, 6, 1, 0},
  parameter int unsigned RGN_LOG2   [MAX_RGN] = '{5, 6, 8, 0},
  localparam int unsigned WAW = ADDR_W - WB_LOG2
) (
  input  logic [ADDR_W-1:0] offset_i,
  output logic              hit_o,
  output logic [WAW-1:0]    base_o,
  output logic [WAW:0]      nwords_o
);

  // cumulative end byte of region k (exclusive)
  function automatic longint unsigned span_end(int unsigned k);
    longint unsigned acc;
    acc = 0;
    for (int unsigned j = 0; j <= k; j++) begin
      acc = acc + (longint'(RGN_BLOCKS[j]) << RGN_LOG2[j]);
    end
    return acc;
  endfunction

  generate
    if (NUM_RGN == 0) begin : g_chip
      assign hit_o    = 1'b1;
      assign base_o   = '0;
      assign nwords_o = (WAW+1)'(1) << WAW;
    end else begin : g_rgn
      logic [MAX_RGN-1:0] below;
      for (genvar g = 0; g < MAX_RGN; g++) begin : g_cmp
        if (g < NUM_RGN) begin : g_live
          localparam longint unsigned END_B = span_end(g);
          assign below[g] = (64'(offset_i) < END_B);
        end else begin : g_off
          assign below[g] = 1'b0;
        end
      end

      // scan downward so the lowest matching region wins
      always_comb begin
        hit_o    = 1'b0;
        base_o   = '0;
        nwords_o = '0;
        for (int i = MAX_RGN - 1; i >= 0; i--) begin
          if (below[i]) begin
            hit_o    = 1'b1;
            base_o   = WAW'((offset_i >> RGN_LOG2[i]) << (RGN_LOG2[i] - WB_LOG2));
            nwords_o = (WAW+1)'(1) << (RGN_LOG2[i] - WB_LOG2);
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/erase_word_sequencer.sv
module erase_word_sequencer
  import erase_pkg::*;
#(
  parameter int unsigned WAW = 9,
  parameter int unsigned DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           hit_i,
  input  logic [WAW-1:0] base_i,
  input  logic [WAW:0]   nwords_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           we_o,
  output logic [WAW-1:0] addr_o,
  output logic [DW-1:0]  wdata_o
);

  erase_state_t   st_q;
  logic [WAW-1:0] addr_q;
  logic [WAW:0]   left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      left_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            addr_q <= base_i;
            left_q <= nwords_i;
            st_q   <= hit_i ? ST_FILL : ST_DONE;
          end
        end
        ST_FILL: begin
          addr_q <= addr_q + 1'b1;
          left_q <= left_q - 1'b1;
          if (left_q == (WAW+1)'(1)) st_q <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = (st_q == ST_DONE);
  assign we_o    = (st_q == ST_FILL);
  assign addr_o  = addr_q;
  assign wdata_o = '1;

endmodule

// File: rtl/erase_block_engine.sv
module erase_block_engine
  import erase_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned WB_LOG2 = 1,
  parameter int unsigned NUM_RGN = 3,
  parameter int unsigned RGN_BLOCKS [MAX_RGN] = '{4, 6, 1, 0},
  parameter int unsigned RGN_LOG2   [MAX_RGN] = '{5, 6, 8, 0},
  localparam int unsigned WAW = ADDR_W - WB_LOG2,
  localparam int unsigned DW  = 8 << WB_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] offset_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              arr_we_o,
  output logic [WAW-1:0]    arr_addr_o,
  output logic [DW-1:0]     arr_wdata_o
);

  logic           hit;
  logic [WAW-1:0] base;
  logic [WAW:0]   nwords;

  erase_region_lookup #(
    .ADDR_W    (ADDR_W),
    .WB_LOG2   (WB_LOG2),
    .NUM_RGN   (NUM_RGN),
    .RGN_BLOCKS(RGN_BLOCKS),
    .RGN_LOG2  (RGN_LOG2)
  ) u_lookup (
    .offset_i (offset_i),
    .hit_o    (hit),
    .base_o   (base),
    .nwords_o (nwords)
  );

  erase_word_sequencer #(
    .WAW (WAW),
    .DW  (DW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .hit_i    (hit),
    .base_i   (base),
    .nwords_i (nwords),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .we_o     (arr_we_o),
    .addr_o   (arr_addr_o),
    .wdata_o  (arr_wdata_o)
  );

endmodule

// File: rtl/erase_engine_chk.sv
module erase_engine_chk #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          arr_we_o,
  input logic [AW-1:0] arr_addr_o,
  input logic [DW-1:0] arr_wdata_o
);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !arr_we_o);

  assert_write_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> busy_o);

  assert_idle_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  assert_busy_until_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we_o && $past(arr_we_o)) |-> (arr_addr_o == $past(arr_addr_o) + 1'b1));

  assert_data_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> (arr_wdata_o == {DW{1'b1}}));

  assert_start_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> !busy_o);

endmodule

bind erase_block_engine erase_engine_chk #(
  .AW (WAW),
  .DW (DW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .arr_we_o    (arr_we_o),
  .arr_addr_o  (arr_addr_o),
  .arr_wdata_o (arr_wdata_o)
);

// File: tb/tb_erase_block_engine.sv
`timescale 1ns/1ps
module tb_erase_block_engine;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_run = 0;
  int n_bad = 0;

  // main config: 1 KiB array, 16-bit words, three regions
  logic       start_a = 1'b0;
  logic [9:0] off_a = '0;
  logic       busy_a, done_a, we_a;
  logic [8:0] addr_a;
  logic [15:0] data_a;

  erase_block_engine #(
    .ADDR_W(10), .WB_LOG2(1), .NUM_RGN(3),
    .RGN_BLOCKS('{4, 6, 1, 0}), .RGN_LOG2('{5, 6, 8, 0})
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_a), .offset_i(off_a),
    .busy_o(busy_a), .done_o(done_a), .arr_we_o(we_a),
    .arr_addr_o(addr_a), .arr_wdata_o(data_a)
  );

  // whole-chip config: 64 bytes, 16-bit words, no regions
  logic       start_b = 1'b0;
  logic [5:0] off_b = '0;
  logic       busy_b, done_b, we_b;
  logic [4:0] addr_b;
  logic [15:0] data_b;

  erase_block_engine #(
    .ADDR_W(6), .WB_LOG2(1), .NUM_RGN(0),
    .RGN_BLOCKS('{0, 0, 0, 0}), .RGN_LOG2('{0, 0, 0, 0})
  ) dut_chip (
    .clk(clk), .rst_n(rst_n), .start_i(start_b), .offset_i(off_b),
    .busy_o(busy_b), .done_o(done_b), .arr_we_o(we_b),
    .arr_addr_o(addr_b), .arr_wdata_o(data_b)
  );

  logic sel = 1'b0;
  wire        m_busy = sel ? busy_b : busy_a;
  wire        m_done = sel ? done_b : done_a;
  wire        m_we   = sel ? we_b : we_a;
  wire [15:0] m_addr = sel ? {11'd0, addr_b} : {7'd0, addr_a};
  wire [15:0] m_data = sel ? data_b : data_a;

  int rb [3] = '{4, 6, 1};
  int rl [3] = '{5, 6, 8};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected word base and word count for the main config
  task automatic expect_main(input int off, output int base, output int n);
    int e;
    e = 0; base = 0; n = 0;
    for (int i = 0; i < 3; i++) begin
      e = e + (rb[i] << rl[i]);
      if (n == 0 && off < e) begin
        base = ((off >> rl[i]) << rl[i]) / 2;
        n    = (1 << rl[i]) / 2;
      end
    end
  endtask

  task automatic drive(input bit s, input bit st, input int off);
    if (s) begin start_b = st; off_b = 6'(off); end
    else   begin start_a = st; off_a = 10'(off); end
  endtask

  task automatic run_one(input bit s, input int off, input int ebase, input int en,
                         input int intr, input string tag);
    int bad_seq, bad_dat, bad_busy, first_act, first_exp;
    bad_seq = 0; bad_dat = 0; bad_busy = 0; first_act = 0; first_exp = 0;
    sel = s;
    @(negedge clk);
    drive(s, 1'b1, off);
    @(negedge clk);
    drive(s, 1'b0, off);
    for (int c = 1; c <= en; c++) begin
      if (!m_we || m_done || int'(m_addr) != ebase + c - 1) begin
        if (bad_seq == 0) begin first_act = int'(m_addr); first_exp = ebase + c - 1; end
        bad_seq++;
      end
      if (m_data != 16'hFFFF) bad_dat++;
      if (!m_busy) bad_busy++;
      if (intr >= 0 && c == 2) drive(s, 1'b1, intr);
      else drive(s, 1'b0, off);
      @(negedge clk);
    end
    chk(bad_seq == 0, {tag, " write sequence"}, first_act, first_exp);
    chk(bad_dat == 0, "R4 data all ones", bad_dat, 0);
    chk(bad_busy == 0, "R7 busy during fill", bad_busy, 0);
    chk(m_done && m_busy && !m_we, {tag, " R9 done after last write"},
        int'({m_done, m_busy, m_we}), 6);
    if (intr >= 0) drive(s, 1'b1, intr);
    @(negedge clk);
    drive(s, 1'b0, off);
    chk(!m_busy && !m_done && !m_we, {tag, " R7 idle after done"},
        int'({m_done, m_busy, m_we}), 0);
  endtask

  task automatic main_seq();
    int b, n;
    repeat (3) @(negedge clk);
    chk(!busy_a && !done_a && !we_a, "R10 reset state", int'({done_a, busy_a, we_a}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_a && !done_a && !we_a && !busy_b, "R10 idle after reset",
        int'({done_a, busy_a, we_a}), 0);
    for (int off = 0; off < 1024; off++) begin
      expect_main(off, b, n);
      run_one(1'b0, off, b, n, -1, (n == 0) ? "R6" : "R1 R2 R3");
    end
    expect_main(130, b, n);
    run_one(1'b0, 130, b, n, 600, "R8 intrude region1");
    expect_main(700, b, n);
    run_one(1'b0, 700, b, n, 5, "R8 intrude region2");
    expect_main(900, b, n);
    run_one(1'b0, 900, b, n, 0, "R8 intrude miss");
    run_one(1'b1, 0, 0, 32, -1, "R5 chip off0");
    run_one(1'b1, 17, 0, 32, -1, "R5 chip off17");
    run_one(1'b1, 63, 0, 32, 9, "R5 R8 chip off63");
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule